// File: doc/BRIEF.md
# SDRAM Concurrent Auto-Precharge Tracker

This block sits beside an SDRAM command scheduler and follows the command stream one cycle at a time for a four-bank device. For each bank it keeps a state (idle, open, reading with auto precharge, precharging) and the countdowns that move the bank between them. For the shared data bus it predicts which read burst owns the bus in each cycle and tags that cycle with the owning bank.

Its main job is the case where a READ or WRITE to one bank arrives while another bank is still running a read with auto precharge. The new command cuts the older burst short. A READ takes over the bus exactly CAS latency cycles after it is registered. A WRITE stops read data at once. The interrupted bank starts its precharge in the same cycle that the new command is registered. The tracker also flags commands that are illegal for the state of their bank, and flags a WRITE that cuts off read data when DQM was not raised two clocks earlier.

CAS latency, burst length and tRP come in on configuration pins. They are taken in only while the tracker is quiet.

Top module: `sdr_apc_tracker`

## Requirements
- R1: In reset, and in the first cycle after it, every bank reads idle and rd_valid, rd_trunc, cmd_err and dqm_err are all low.
- R2: Command codes on cmd_code are: 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE; codes 5 to 7 act as NOP. Bank b's state appears on bank_state[2b+1:2b], coded as 0 idle, 1 open, 2 reading with auto precharge, 3 precharging. An ACTIVATE to an idle bank makes it read open in the next cycle.
- R3: A READ to an open bank, registered at edge t, makes rd_valid high with rd_bank equal to that bank in the cycles after edges t+CL to t+CL+BL-1, unless a later command cuts the burst.
- R4: A READ to an open bank with cmd_autopre high puts that bank in state 2. If nothing interrupts it, the bank enters state 3 at edge t+BL, stays there for tRP cycles, and then reads idle.
- R5: A READ registered at edge t that is not cut by a WRITE ends any earlier burst at edge t+CL. The interrupted bank therefore delivers as many words as cycles separate the two READs, up to its burst length. rd_trunc is high for one cycle, alongside the first word of the new burst, whenever an older burst still had words left.
- R6: A legal READ or WRITE to one bank moves every other bank in state 2 into state 3 at that same edge. Such a bank reads idle tRP cycles later.
- R7: A legal WRITE clears all read data from the next cycle on (rd_valid low). rd_trunc pulses in that cycle if any read word was still due.
- R8: dqm_err pulses in the cycle after a legal WRITE that cuts off due read data while dqm was low at the edge two clocks before the WRITE. With dqm high there, dqm_err stays low.
- R9: A READ or WRITE to a bank that is not open, or an ACTIVATE to a bank that is not idle, pulses cmd_err in the next cycle and changes no bank state and no data prediction.
- R10: A PRECHARGE to an open bank moves it to state 3 for tRP cycles and then to idle. A PRECHARGE to a bank in any other state is ignored without error.
- R11: cfg_cas 3 selects CL 3 and any other value selects CL 2. cfg_burst code k selects BL 2^k (1, 2, 4, 8). cfg_trp gives tRP, with 0 treated as 1. These settings are taken in only at an edge where all banks are idle and no read word is due; changes at other times have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_code | input | 3 | Command registered this edge |
| cmd_bank | input | 2 | Bank addressed by the command |
| cmd_autopre | input | 1 | Auto-precharge request with a READ |
| dqm | input | 1 | Data mask level driven to the device |
| cfg_cas | input | 2 | CAS latency setting |
| cfg_burst | input | 2 | Burst length code |
| cfg_trp | input | 4 | Precharge time in cycles |
| bank_state | output | 8 | Two-bit state of each bank |
| rd_valid | output | 1 | Predicted read word on the bus this cycle |
| rd_bank | output | 2 | Bank owning the current read word |
| rd_trunc | output | 1 | One-cycle pulse when a burst is cut short |
| cmd_err | output | 1 | Illegal command for the bank's state |
| dqm_err | output | 1 | Interrupting WRITE issued without DQM lead |

## Verification
The assertions assume that cmd_code carries only the five defined codes, or values that act as NOP, and that configuration changes matter only at quiet edges. Under those inputs a precharging bank can leave only toward idle, a killed auto-precharge bank must be precharging one cycle later, and the timing settings cannot move while a burst is due. The random stimulus draws only legal command codes. It deliberately sends many commands to banks in the wrong state and changes the configuration pins at random times, so the quiet-edge sampling rule and the error paths are exercised rather than avoided.

// File: rtl/sdr_apc_pkg.sv
// Shared types for the concurrent auto-precharge tracker.
// Assumes a single command per clock on a plain encoded bus.
package sdr_apc_pkg;

    typedef enum logic [1:0] {
        BK_IDLE   = 2'd0,
        BK_OPEN   = 2'd1,
        BK_RDAP   = 2'd2,
        BK_PRECH  = 2'd3
    } bank_st_e;

    typedef enum logic [2:0] {
        C_NOP = 3'd0,
        C_ACT = 3'd1,
        C_RD  = 3'd2,
        C_WR  = 3'd3,
        C_PRE = 3'd4
    } cmd_e;

    // Burst length from its two-bit code: 1, 2, 4 or 8.
    function automatic logic [3:0] burst_of(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/sdr_apc_bank.sv
// One bank's state machine: idle, open, read with auto precharge, precharging.
// Assumes the go_* strobes are already checked against the current state by
// the parent; kill is raised when a legal access hits some other bank.
module sdr_apc_bank
    import sdr_apc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_act,
    input  logic             go_rdap,
    input  logic             go_pre,
    input  logic             kill,
    input  logic [CNT_W-1:0] burst_len,
    input  logic [CNT_W-1:0] trp,
    output bank_st_e         state
);

    logic [CNT_W-1:0] cnt;

    // Advance the bank state and its countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= BK_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                BK_IDLE: if (go_act) state <= BK_OPEN;
                BK_OPEN: begin
                    if (go_rdap) begin
                        state <= BK_RDAP;
                        cnt   <= burst_len - CNT_W'(1);
                    end else if (go_pre) begin
                        state <= BK_PRECH;
                        cnt   <= trp - CNT_W'(1);
                    end
                end
                BK_RDAP: begin
                    if (kill || cnt == '0) begin
                        state <= BK_PRECH;
                        cnt   <= trp - CNT_W'(1);
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                default: begin
                    if (cnt == '0) state <= BK_IDLE;
                    else           cnt   <= cnt - CNT_W'(1);
                end
            endcase
        end
    end

    // R4
    prech_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == BK_PRECH |=> state inside {BK_PRECH, BK_IDLE});

    // R6
    kill_prech_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BK_RDAP && kill) |=> state == BK_PRECH);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BK_IDLE && !go_act) |=> state == BK_IDLE);

endmodule

// File: rtl/sdr_apc_rdsched.sv
// Read data bus scheduler: delays each READ by CAS latency, then plays out
// its burst. A newer launch reaching the bus replaces the running burst;
// a WRITE flushes everything at once.
// Assumes cas and burst_len are stable whenever quiet is low.
module sdr_apc_rdsched #(
    parameter int BANK_W = 2,
    parameter int MAX_CL = 3,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [BANK_W-1:0] launch_bank,
    input  logic              wr_cut,
    input  logic [1:0]        cas,
    input  logic [CNT_W-1:0]  burst_len,
    output logic              rd_valid,
    output logic [BANK_W-1:0] rd_bank,
    output logic              rd_trunc,
    output logic              live,
    output logic              quiet
);

    logic [MAX_CL-1:0] pipe_v;
    logic [BANK_W-1:0] pipe_b [MAX_CL];
    logic [MAX_CL-1:0] keep;
    logic              tap_v;
    logic [BANK_W-1:0] tap_b;
    logic [CNT_W-1:0]  left;

    // Pick the pipeline stage that matches CAS latency; older stages drop out.
    always_comb begin
        tap_v = 1'b0;
        tap_b = '0;
        for (int i = 0; i < MAX_CL; i++) begin
            keep[i] = (i < int'(cas) - 1);
            if (i == int'(cas) - 1) begin
                tap_v = pipe_v[i];
                tap_b = pipe_b[i];
            end
        end
    end

    assign live  = (rd_valid && left != '0) || (|pipe_v);
    assign quiet = !rd_valid && !(|pipe_v);

    // Shift launches toward the bus; a WRITE empties the pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n || wr_cut) begin
            pipe_v <= '0;
            for (int i = 0; i < MAX_CL; i++) pipe_b[i] <= '0;
        end else begin
            pipe_v[0] <= launch;
            pipe_b[0] <= launch_bank;
            for (int i = 1; i < MAX_CL; i++) begin
                pipe_v[i] <= pipe_v[i-1] & keep[i-1];
                pipe_b[i] <= pipe_b[i-1];
            end
        end
    end

    // Own the bus: start, continue, replace or stop the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_bank  <= '0;
            left     <= '0;
            rd_trunc <= 1'b0;
        end else if (wr_cut) begin
            rd_valid <= 1'b0;
            left     <= '0;
            rd_trunc <= live;
        end else if (tap_v) begin
            rd_valid <= 1'b1;
            rd_bank  <= tap_b;
            left     <= burst_len - CNT_W'(1);
            rd_trunc <= rd_valid && left != '0;
        end else begin
            rd_trunc <= 1'b0;
            if (rd_valid && left != '0) left <= left - CNT_W'(1);
            else                        rd_valid <= 1'b0;
        end
    end

    // R3
    start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(tap_v));

    // R7
    write_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cut |=> !rd_valid);

    // R5
    trunc_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_trunc |-> (rd_valid || $past(wr_cut)));

    // R3
    always_ff @(posedge clk) begin
        if (rst_n && rd_valid)
            left_range_chk: assert (left < burst_len);
    end

endmodule

// File: rtl/sdr_apc_tracker.sv
// Top of the concurrent auto-precharge tracker. Decodes each command against
// the addressed bank's state, drives the per-bank machines and the read bus
// scheduler, keeps the DQM history and latches timing settings when quiet.
// Assumes one command per cycle and cfg_* meaningful only at quiet edges.
module sdr_apc_tracker
    import sdr_apc_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int MAX_CL = 3,
    parameter int MAX_BL = 8,
    parameter int TRP_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           cmd_code,
    input  logic [$clog2(NBANK)-1:0] cmd_bank,
    input  logic                 cmd_autopre,
    input  logic                 dqm,
    input  logic [1:0]           cfg_cas,
    input  logic [1:0]           cfg_burst,
    input  logic [TRP_W-1:0]     cfg_trp,
    output logic [2*NBANK-1:0]   bank_state,
    output logic                 rd_valid,
    output logic [$clog2(NBANK)-1:0] rd_bank,
    output logic                 rd_trunc,
    output logic                 cmd_err,
    output logic                 dqm_err
);

    localparam int BANK_W = $clog2(NBANK);
    localparam int BL_W   = $clog2(MAX_BL) + 1;
    localparam int CNT_W  = (TRP_W > BL_W) ? TRP_W : BL_W;

    bank_st_e         st [NBANK];
    bank_st_e         hit;
    logic [1:0]       cl_q;
    logic [CNT_W-1:0] bl_q, trp_q;
    logic             dqm_d1, dqm_d2;
    logic             is_rw, acc, act_ok, bad, rd_go, wr_go;
    logic             all_idle, bus_quiet, live;

    // Decode the command against the addressed bank's current state.
    always_comb begin
        hit      = st[cmd_bank];
        is_rw    = (cmd_code == C_RD) || (cmd_code == C_WR);
        acc      = is_rw && hit == BK_OPEN;
        act_ok   = (cmd_code == C_ACT) && hit == BK_IDLE;
        bad      = (is_rw && hit != BK_OPEN) || ((cmd_code == C_ACT) && hit != BK_IDLE);
        rd_go    = acc && cmd_code == C_RD;
        wr_go    = acc && cmd_code == C_WR;
        all_idle = 1'b1;
        for (int b = 0; b < NBANK; b++)
            if (st[b] != BK_IDLE) all_idle = 1'b0;
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic sel;
        assign sel = (cmd_bank == BANK_W'(g));
        sdr_apc_bank #(.CNT_W(CNT_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .go_act    (act_ok && sel),
            .go_rdap   (rd_go && cmd_autopre && sel),
            .go_pre    ((cmd_code == C_PRE) && sel),
            .kill      (acc && !sel),
            .burst_len (bl_q),
            .trp       (trp_q),
            .state     (st[g])
        );
        assign bank_state[2*g +: 2] = st[g];
    end

    sdr_apc_rdsched #(.BANK_W(BANK_W), .MAX_CL(MAX_CL), .CNT_W(CNT_W)) u_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (rd_go),
        .launch_bank (cmd_bank),
        .wr_cut      (wr_go),
        .cas         (cl_q),
        .burst_len   (bl_q),
        .rd_valid    (rd_valid),
        .rd_bank     (rd_bank),
        .rd_trunc    (rd_trunc),
        .live        (live),
        .quiet       (bus_quiet)
    );

    // Take in timing settings only while nothing is open or due.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cl_q  <= 2'd3;
            bl_q  <= CNT_W'(4);
            trp_q <= CNT_W'(2);
        end else if (all_idle && bus_quiet) begin
            cl_q  <= (cfg_cas == 2'd3) ? 2'd3 : 2'd2;
            bl_q  <= CNT_W'(burst_of(cfg_burst));
            trp_q <= (cfg_trp == '0) ? CNT_W'(1) : CNT_W'(cfg_trp);
        end
    end

    // Remember DQM for the two-clock lead check and register the error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dqm_d1  <= 1'b0;
            dqm_d2  <= 1'b0;
            cmd_err <= 1'b0;
            dqm_err <= 1'b0;
        end else begin
            dqm_d1  <= dqm;
            dqm_d2  <= dqm_d1;
            cmd_err <= bad;
            dqm_err <= wr_go && live && !dqm_d2;
        end
    end

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(all_idle && bus_quiet) |=> ($stable(bl_q) && $stable(cl_q) && $stable(trp_q)));

    // R8
    dqm_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dqm_err |-> $past(cmd_code) == C_WR);

    // R9
    cmd_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(cmd_code) != C_NOP);

endmodule

// File: tb/tb_sdr_apc_tracker.sv
module tb_sdr_apc_tracker;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] cmd_code;
    logic [1:0] cmd_bank;
    logic       cmd_autopre, dqm;
    logic [1:0] cfg_cas, cfg_burst;
    logic [3:0] cfg_trp;
    logic [7:0] bank_state;
    logic       rd_valid, rd_trunc, cmd_err, dqm_err;
    logic [1:0] rd_bank;

    always #5 clk = ~clk;

    sdr_apc_tracker dut (
        .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
        .cmd_autopre(cmd_autopre), .dqm(dqm), .cfg_cas(cfg_cas),
        .cfg_burst(cfg_burst), .cfg_trp(cfg_trp), .bank_state(bank_state),
        .rd_valid(rd_valid), .rd_bank(rd_bank), .rd_trunc(rd_trunc),
        .cmd_err(cmd_err), .dqm_err(dqm_err)
    );

    localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;

    int n_tests = 0, n_fail = 0, cyc = 0;
    bit done = 0;
    int m_st [4], m_until [4];
    int m_cl = 3, m_bl = 4, m_trp = 2;
    bit sv [64], tr [64], dq [64];
    int sb [64];
    bit e_cerr, e_derr;
    int obs_words [4];
    int obs_trunc;

    function automatic int bl_of(input logic [1:0] c);  return 1 << c; endfunction
    function automatic int cl_of(input logic [1:0] c);  return (c == 2'd3) ? 3 : 2; endfunction
    function automatic int trp_of(input logic [3:0] c); return (c == 0) ? 1 : int'(c); endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Reference model: one edge, derived from the requirements.
    task automatic model_edge();
        int n = cyc;
        int b = int'(cmd_bank);
        int s = m_st[b];
        bit quiet = 1, acc, live = 0;
        for (int i = 0; i < 4; i++) if (m_st[i] != 0) quiet = 0;
        for (int k = -1; k <= 12; k++) if (sv[(n + k) & 63]) quiet = 0;
        sv[(n + 13) & 63] = 0; tr[(n + 13) & 63] = 0;
        sv[(n + 14) & 63] = 0; tr[(n + 14) & 63] = 0;
        sv[(n + 15) & 63] = 0; tr[(n + 15) & 63] = 0;
        acc = (cmd_code == RD || cmd_code == WR) && s == 1;
        e_cerr = ((cmd_code == RD || cmd_code == WR) && s != 1) || (cmd_code == ACT && s != 0);
        e_derr = 0;
        for (int i = 0; i < 4; i++) begin
            if (m_st[i] == 2 && m_until[i] == n) begin m_st[i] = 3; m_until[i] = n + m_trp; end
            else if (m_st[i] == 3 && m_until[i] == n) m_st[i] = 0;
        end
        if (acc)
            for (int i = 0; i < 4; i++)
                if (i != b && m_st[i] == 2) begin m_st[i] = 3; m_until[i] = n + m_trp; end
        if (cmd_code == ACT && s == 0) m_st[b] = 1;
        if (acc && cmd_code == RD && cmd_autopre) begin m_st[b] = 2; m_until[b] = n + m_bl; end
        if (cmd_code == PRE && s == 1) begin m_st[b] = 3; m_until[b] = n + m_trp; end
        if (acc && cmd_code == WR) begin
            for (int k = 0; k <= 12; k++) if (sv[(n + k) & 63]) live = 1;
            e_derr = live && !((n >= 2) ? dq[(n - 2) & 63] : 1'b0);
            for (int k = 0; k <= 12; k++) sv[(n + k) & 63] = 0;
            tr[n & 63] = live;
        end
        if (acc && cmd_code == RD) begin
            int k0 = n + m_cl;
            tr[k0 & 63] = sv[k0 & 63];
            for (int k = 0; k <= 12; k++) sv[(k0 + k) & 63] = 0;
            for (int k = 0; k < m_bl; k++) begin sv[(k0 + k) & 63] = 1; sb[(k0 + k) & 63] = b; end
        end
        dq[n & 63] = dqm;
        if (quiet) begin m_cl = cl_of(cfg_cas); m_bl = bl_of(cfg_burst); m_trp = trp_of(cfg_trp); end
    endtask

    task automatic compare();
        int n = cyc & 63;
        for (int b = 0; b < 4; b++)
            chk(int'(bank_state[2*b +: 2]) == m_st[b], "R2 bank state", int'(bank_state[2*b +: 2]), m_st[b]);
        chk(rd_valid == sv[n], "R3 rd_valid", int'(rd_valid), int'(sv[n]));
        if (sv[n]) chk(int'(rd_bank) == sb[n], "R3 rd_bank", int'(rd_bank), sb[n]);
        chk(rd_trunc == tr[n], "R5 rd_trunc", int'(rd_trunc), int'(tr[n]));
        chk(cmd_err == e_cerr, "R9 cmd_err", int'(cmd_err), int'(e_cerr));
        chk(dqm_err == e_derr, "R8 dqm_err", int'(dqm_err), int'(e_derr));
        if (rd_valid) obs_words[rd_bank]++;
        if (rd_trunc) obs_trunc++;
    endtask

    task automatic step(input logic [2:0] c, input int b, input bit ap, input bit dm);
        cmd_code = c; cmd_bank = b[1:0]; cmd_autopre = ap; dqm = dm;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        cyc++;
    endtask

    task automatic idle(input int k, input bit dm);
        for (int i = 0; i < k; i++) step(NOP, 0, 0, dm);
    endtask

    task automatic clear_obs();
        for (int i = 0; i < 4; i++) obs_words[i] = 0;
        obs_trunc = 0;
    endtask

    function automatic int st_of(input int b);
        return int'(bank_state[2*b +: 2]);
    endfunction

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_until[i] = 0; end
        for (int i = 0; i < 64; i++) begin sv[i] = 0; tr[i] = 0; dq[i] = 0; sb[i] = 0; end
        rst_n = 0; cmd_code = NOP; cmd_bank = 0; cmd_autopre = 0; dqm = 0;
        cfg_cas = 2'd3; cfg_burst = 2'd2; cfg_trp = 4'd2;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(bank_state == 8'h00, "R1 banks idle in reset", int'(bank_state), 0);
        chk({rd_valid, rd_trunc, cmd_err, dqm_err} == 4'b0, "R1 outputs low in reset",
            int'({rd_valid, rd_trunc, cmd_err, dqm_err}), 0);
        rst_n = 1;
        step(NOP, 0, 0, 0);
        chk(bank_state == 8'h00 && !rd_valid, "R1 first cycle idle", int'(bank_state), 0);

        // R4: uninterrupted auto-precharge read, CL3 BL4 tRP2
        step(ACT, 0, 0, 0);
        chk(st_of(0) == 1, "R2 activate opens bank", st_of(0), 1);
        clear_obs();
        step(RD, 0, 1, 0);
        chk(st_of(0) == 2, "R4 read-ap state", st_of(0), 2);
        idle(3, 0);
        chk(st_of(0) == 2, "R4 still reading at t+3", st_of(0), 2);
        step(NOP, 0, 0, 0);
        chk(st_of(0) == 3, "R4 precharge at t+BL", st_of(0), 3);
        step(NOP, 0, 0, 0);
        chk(st_of(0) == 3, "R4 precharge holds tRP", st_of(0), 3);
        step(NOP, 0, 0, 0);
        chk(st_of(0) == 0, "R4 idle after tRP", st_of(0), 0);
        idle(2, 0);
        chk(obs_words[0] == 4, "R3 full burst words", obs_words[0], 4);

        // R5 / R6: READ to bank 1 two cycles after READ-AP to bank 0
        step(ACT, 0, 0, 0);
        step(ACT, 1, 0, 0);
        clear_obs();
        step(RD, 0, 1, 0);
        step(NOP, 0, 0, 0);
        step(RD, 1, 0, 0);
        chk(st_of(0) == 3, "R6 interrupted bank precharging", st_of(0), 3);
        idle(8, 0);
        chk(obs_words[0] == 2, "R5 truncated burst words", obs_words[0], 2);
        chk(obs_words[1] == 4, "R5 new burst words", obs_words[1], 4);
        chk(obs_trunc == 1, "R5 one truncation pulse", obs_trunc, 1);
        chk(st_of(0) == 0, "R6 idle after tRP", st_of(0), 0);

        // R7 / R8: WRITE cuts read data, without DQM lead
        step(ACT, 0, 0, 0);
        step(RD, 1, 0, 0);
        idle(3, 0);
        step(WR, 0, 0, 0);
        chk(!rd_valid, "R7 data stops after write", int'(rd_valid), 0);
        chk(rd_trunc, "R7 truncation on write", int'(rd_trunc), 1);
        chk(dqm_err, "R8 missing dqm lead flagged", int'(dqm_err), 1);
        idle(6, 0);
        // R8: same with DQM raised two clocks ahead
        step(RD, 1, 0, 0);
        idle(3, 1);
        step(WR, 0, 0, 1);
        chk(!dqm_err, "R8 dqm lead accepted", int'(dqm_err), 0);
        chk(rd_trunc, "R7 truncation on write with dqm", int'(rd_trunc), 1);
        idle(6, 0);

        // R9: illegal commands
        step(RD, 2, 0, 0);
        chk(cmd_err && st_of(2) == 0, "R9 read to idle bank", int'(cmd_err), 1);
        step(ACT, 1, 0, 0);
        chk(cmd_err && st_of(1) == 1, "R9 activate to open bank", int'(cmd_err), 1);

        // R10: precharge open bank, then precharge idle bank
        step(PRE, 1, 0, 0);
        chk(st_of(1) == 3, "R10 precharge entered", st_of(1), 3);
        step(NOP, 0, 0, 0);
        step(NOP, 0, 0, 0);
        chk(st_of(1) == 0, "R10 idle after tRP", st_of(1), 0);
        step(PRE, 1, 0, 0);
        chk(st_of(1) == 0 && !cmd_err, "R10 precharge on idle ignored", st_of(1), 0);

        // R11: burst setting ignored while a bank is open
        cfg_burst = 2'd3;
        clear_obs();
        step(RD, 0, 0, 0);
        idle(12, 0);
        chk(obs_words[0] == 4, "R11 burst change ignored while open", obs_words[0], 4);
        step(PRE, 0, 0, 0);
        idle(4, 0);
        // R11: taken in while quiet, BL8
        clear_obs();
        step(ACT, 2, 0, 0);
        step(RD, 2, 0, 0);
        idle(12, 0);
        chk(obs_words[2] == 8, "R11 BL8 after quiet edge", obs_words[2], 8);
        step(PRE, 2, 0, 0);
        idle(4, 0);
        // R11: CL2 and tRP 0 treated as 1
        cfg_cas = 2'd2; cfg_trp = 4'd0; cfg_burst = 2'd1;
        step(NOP, 0, 0, 0);
        step(ACT, 3, 0, 0);
        step(RD, 3, 0, 0);
        step(NOP, 0, 0, 0);
        chk(!rd_valid, "R11 CL2 no data at t+1", int'(rd_valid), 0);
        step(NOP, 0, 0, 0);
        chk(rd_valid && rd_bank == 2'd3, "R11 CL2 data at t+2", int'(rd_valid), 1);
        idle(4, 0);
        step(PRE, 3, 0, 0);
        chk(st_of(3) == 3, "R11 precharge with tRP code 0", st_of(3), 3);
        step(NOP, 0, 0, 0);
        chk(st_of(3) == 0, "R11 tRP code 0 acts as 1", st_of(3), 0);

        // Random traffic checked against the model every cycle
        for (int i = 0; i < 6000; i++) begin
            int r = int'($urandom % 100);
            logic [2:0] c;
            if ($urandom % 40 == 0) begin
                cfg_cas = 2'($urandom); cfg_burst = 2'($urandom); cfg_trp = 4'($urandom % 6);
            end
            c = (r < 22) ? ACT : (r < 55) ? RD : (r < 65) ? WR : (r < 77) ? PRE : NOP;
            step(c, int'($urandom % 4), bit'($urandom % 2), bit'($urandom % 2));
        end
        idle(30, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", 150000);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule